// File: doc/BRIEF.md
# Signaling Channel Serial Input Buffer

This block collects the bits of two low-rate signaling channels that arrive on serial pins, each channel delivering two bits in every 125 µs frame. An external data clock marks the bits; the block samples each data pin on every falling edge of that clock and keeps the two newest bits of every channel in a short shift register. Extra clock edges within a frame keep shifting, so the newest bits displace older ones. If fewer than two edges arrive, bits from the previous frame stay in the register.

The frame sync pin, not a bit count, ends a frame. On each rising edge of frame sync the buffered bits of both channels move into a parallel word. A one-cycle strobe marks the word for the burst modulator, which must take it in that cycle. The word then holds until the next frame. The interface has no back-pressure: the modulator has no ready signal, because the frame boundary sets the schedule and cannot be held off. Frame sync, data clock and data pins are all asynchronous to the system clock. They are synchronised and their edges are detected on a system clock at least four times faster than the data clock. The data clock may run anywhere from 16 kHz to 4.1 MHz.

Top module: `sigch_inbuf`

## Requirements
- R1: While reset is held and in the cycle after it is released, word_data is all zeros and word_valid is low. Both channel buffers start at zero.
- R2: Two falling data-clock edges follow a frame-sync rise. At the next frame-sync rise word_data carries {ch1 first, ch1 second, ch2 first, ch2 second} in bits 3 down to 0. Channel 1 is sdata_in[0] and channel 2 is sdata_in[1].
- R3: Every further falling edge in a frame shifts one new bit into each channel and drops the oldest, so the word holds the last two bits captured.
- R4: With one or zero falling edges in a frame, the transferred word holds whatever each two-bit buffer contains, including bits left over from earlier frames.
- R5: Each frame-sync rise gives exactly one word_valid pulse of one cycle. It appears SYNC_STAGES+1 clock edges after the first edge that samples frame sync high.
- R6: Between strobes word_data does not change.
- R7: A frame-sync rise and a data-clock fall may be detected in the same cycle. The word then takes the buffer contents from before that shift. The coincident bit becomes the first bit of the new frame.
- R8: Rising data-clock edges and data-pin changes away from a falling edge leave the buffers unchanged.
- R9: A falling frame-sync edge transfers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_in | input | 1 | Asynchronous 8 kHz frame sync; rising edge ends a frame |
| dclk_in | input | 1 | Asynchronous data clock; falling edge captures a bit |
| sdata_in | input | NUM_CH (2) | Serial data pins; bit 0 is channel 1 |
| word_data | output | NUM_CH*BITS_PER_CH (4) | Transferred word, channel 1 in the top bits, oldest bit first |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The frame transfer and the bit shift can land in the same system cycle when the data-clock fall and the frame-sync rise are synchronised together. The bench makes this happen by dropping the data clock and raising frame sync on the same clock edge. It then checks two things: the strobed word must hold the bits from before the shift, and the coincident bit must appear as the first bit of the next word. A behavioural model fed from a delay queue of pin samples tracks word_data and word_valid on every clock. Directed frames with two, three, one and zero data-clock falls check the captured values against hand-derived words.

// File: rtl/sigch_pkg.sv
package sigch_pkg;
  // Default geometry: two signaling channels, two bits each per frame.
  localparam int unsigned SIG_CH   = 2;
  localparam int unsigned SIG_BITS = 2;
  localparam int unsigned SIG_SYNC = 2;

  // Fixed positions inside the synchroniser vector.
  localparam int unsigned PIN_FSYNC = 0;
  localparam int unsigned PIN_DCLK  = 1;
  localparam int unsigned PIN_DATA0 = 2;
endpackage

// File: rtl/sigch_sync.sv
module sigch_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/sigch_edge.sv
module sigch_edge #(
  parameter bit RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse = ~lvl & prev_q;
    end
  endgenerate

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/sigch_lane.sv
module sigch_lane #(
  parameter int BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [BITS-1:0] bits
);
  logic [BITS-1:0] sr_q;

  // Oldest bit sits at the MSB, newest at the LSB.
  always_ff @(posedge clk) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[BITS-2:0], din};
  end

  assign bits = sr_q;

  // R3
  newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(din));

  // R3
  displace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[BITS-1:1] == $past(sr_q[BITS-2:0]));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/sigch_inbuf.sv
module sigch_inbuf
  import sigch_pkg::*;
#(
  parameter int NUM_CH      = SIG_CH,
  parameter int BITS_PER_CH = SIG_BITS,
  parameter int SYNC_STAGES = SIG_SYNC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fsync_in,
  input  logic                          dclk_in,
  input  logic [NUM_CH-1:0]             sdata_in,
  output logic [NUM_CH*BITS_PER_CH-1:0] word_data,
  output logic                          word_valid
);
  localparam int PW = NUM_CH + 2;
  localparam int WW = NUM_CH * BITS_PER_CH;

  logic [PW-1:0] pins_raw, pins_s;
  logic          frame_rise, bit_fall;
  logic [WW-1:0] buf_word;
  logic [WW-1:0] word_q;
  logic          valid_q;

  assign pins_raw = {sdata_in, dclk_in, fsync_in};

  sigch_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_raw), .sync_out(pins_s));

  sigch_edge #(.RISE(1'b1)) u_fs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[PIN_FSYNC]), .pulse(frame_rise));

  sigch_edge #(.RISE(1'b0)) u_dc_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s[PIN_DCLK]), .pulse(bit_fall));

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      logic [BITS_PER_CH-1:0] lane_bits;
      sigch_lane #(.BITS(BITS_PER_CH)) u_lane (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_fall),
        .din(pins_s[PIN_DATA0 + ch]), .bits(lane_bits));
      // Channel 1 lands in the top bits of the word.
      assign buf_word[(NUM_CH-1-ch)*BITS_PER_CH +: BITS_PER_CH] = lane_bits;
    end
  endgenerate

  // The transfer reads the buffer before any shift of the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= frame_rise;
      if (frame_rise) word_q <= buf_word;
    end
  end

  assign word_data  = word_q;
  assign word_valid = valid_q;

  // R2
  word_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_data == $past(buf_word));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R7
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rise && bit_fall) |=> word_data == $past(buf_word));
endmodule

// File: tb/sigch_inbuf_bench.sv
module sigch_inbuf_bench;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync_in = 1'b0;
  logic       dclk_in = 1'b0;
  logic [1:0] sdata_in = 2'b00;
  logic [3:0] word_data;
  logic       word_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sigch_inbuf #(.NUM_CH(2), .BITS_PER_CH(2), .SYNC_STAGES(S)) u_sigch_inbuf (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .dclk_in(dclk_in),
    .sdata_in(sdata_in), .word_data(word_data), .word_valid(word_valid));

  // Behavioural model: delay queue of pin samples, newest at index 0.
  logic [3:0] hist[$];
  logic [1:0] m_c1, m_c2;
  logic [3:0] m_word;
  logic       m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < S + 2; i++) hist.push_front(4'b0000);
      m_c1 = 2'b00; m_c2 = 2'b00; m_word = 4'b0000; m_valid = 1'b0;
    end else begin
      logic [3:0] cur, old;
      hist.push_front({sdata_in, dclk_in, fsync_in});
      void'(hist.pop_back());
      cur = hist[S];
      old = hist[S+1];
      m_valid = cur[0] & ~old[0];
      if (m_valid) m_word = {m_c1, m_c2};
      if (!cur[1] && old[1]) begin
        m_c1 = {m_c1[0], cur[2]};
        m_c2 = {m_c2[0], cur[3]};
      end
    end
  end

  // Per-cycle comparison and strobe monitor, away from the active edge.
  logic [3:0] last_word = 4'b0000;
  int         vcount = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (word_valid !== m_valid) begin
        fails++;
        $display("FAIL R5 word_valid actual=%b expected=%b", word_valid, m_valid);
      end
      checks++;
      if (word_data !== m_word) begin
        fails++;
        $display("FAIL %s word_data actual=%b expected=%b",
                 m_valid ? "R2" : "R6", word_data, m_word);
      end
      if (word_valid) begin
        last_word = word_data;
        vcount++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic c1, input logic c2);
    @(negedge clk); sdata_in = {c2, c1}; dclk_in = 1'b1;
    repeat (4) @(negedge clk);
    dclk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  int fcount = 0;
  task automatic fsync_pulse();
    @(negedge clk); fsync_in = 1'b1; fcount++;
    repeat (4) @(negedge clk);
    fsync_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1", word_data, 4'b0000);
    check("R1", word_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", word_data, 4'b0000);
    check("R1", word_valid, 1'b0);

    // R5 latency: first sampling edge of fsync high, valid after S+1 edges
    @(negedge clk); fsync_in = 1'b1; fcount++;
    for (int k = 0; k < S; k++) begin
      @(negedge clk);
      check("R5", word_valid, 1'b0);
    end
    @(negedge clk);
    check("R5", word_valid, 1'b1);
    fsync_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R9", vcount, 1);

    // R2: two bits per channel
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1);
    fsync_pulse();
    check("R2", last_word, 4'b1001);

    // R3: three edges, oldest bit displaced
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b1);
    fsync_pulse();
    check("R3", last_word, 4'b1011);

    // R4: one edge, leftover bits remain
    send_bit(1'b0, 1'b0);
    fsync_pulse();
    check("R4", last_word, 4'b0010);

    // R4: no edges at all
    fsync_pulse();
    check("R4", last_word, 4'b0010);

    // R8: data toggles and rising edges without a fall do nothing
    @(negedge clk); dclk_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sdata_in = sdata_in ^ 2'b11;
    end
    @(negedge clk); sdata_in = 2'b11;
    repeat (4) @(negedge clk);
    dclk_in = 1'b0;
    repeat (4) @(negedge clk);
    dclk_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sdata_in = sdata_in ^ 2'b01;
    end
    fsync_pulse();
    check("R8", last_word, 4'b0101);
    @(negedge clk); dclk_in = 1'b0;   // this fall shifts one bit (1,1)
    repeat (6) @(negedge clk);

    // R7: fall and frame rise on the same edge
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    @(negedge clk); sdata_in = 2'b10; dclk_in = 1'b1;
    repeat (4) @(negedge clk);
    dclk_in = 1'b0; fsync_in = 1'b1; fcount++;
    repeat (4) @(negedge clk);
    fsync_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R7", last_word, 4'b1100);
    send_bit(1'b1, 1'b0);
    fsync_pulse();
    check("R7", last_word, 4'b0110);

    // R9: one strobe per rising frame edge, none on falling edges
    check("R9", vcount, fcount);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule